// File: doc/BRIEF.md
# Low-Half Array Multiplier

This block multiplies two W-bit operands and keeps only the least significant W bits of the 2W-bit product. The default is W = 32. Inside, an array of AND gates forms one partial product for each multiplier bit. Partial product j is the multiplicand gated by multiplier bit j and moved up j places. A chain of ripple-carry rows then adds these partial products one at a time into a running sum.

Each row holds adder cells only at bit positions at or above its own shift. The lowest cell of a row is a half adder, because its incoming carry is known to be zero. Carries that would leave bit W-1 are dropped, so no logic exists for the upper half of the product. Bits below W depend only on the low W bits of the operands, so the same array serves unsigned and two's complement operands without any sign correction.

The combinational array feeds one output register with a synchronous active-high reset. A result therefore appears one clock after its operands are presented.

Top module: `lowmul_array`

## Requirements
- R1: While `rst` is high the registered output is cleared, and it reads zero in the first cycle after reset is released.
- R2: One clock after operands are presented, `prod` equals bits W-1..0 of the unsigned product of `mul_a` and `mul_b`.
- R3: When both operands are read as two's complement numbers, `prod` equals the low W bits of their signed product, with no mode input.
- R4: If either operand is zero, `prod` is zero one clock later.
- R5: A multiplier of one returns the multiplicand unchanged, and a multiplicand of one returns the multiplier unchanged.
- R6: A multiplicand of all ones (minus one) times 2^i gives the two's complement negation of 2^i, for every i from 0 to W-1.
- R7: Product bits at W and above are discarded. For example, (3<<i)*3 for i from 0 to W-1 keeps only the low W bits of 9<<i.
- R8: A multiplier with only bit j set yields the multiplicand shifted left by j, with zeros in the j low bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the output register |
| mul_a | input | W | Multiplicand |
| mul_b | input | W | Multiplier |
| prod | output | W | Registered low W bits of mul_a * mul_b |

## Verification
The condition hardest to reach is a carry that ripples through a whole row and then out of bit W-1, where it must disappear. Operands such as (3<<i)*3 and all-ones times powers of two, swept over every shift position, drive long carry chains into the top bit. Random operand pairs are compared each cycle against a behavioural model that keeps both an unsigned and a signed 64-bit product. This shows that one set of output bits agrees with both readings.

// File: rtl/lowmul_pkg.sv
package lowmul_pkg;

  function automatic logic fa_sum(input logic x, input logic y, input logic ci);
    return x ^ y ^ ci;
  endfunction

  function automatic logic fa_carry(input logic x, input logic y, input logic ci);
    return (x & y) | (ci & (x ^ y));
  endfunction

endpackage

// File: rtl/lowmul_row.sv
// One accumulation row: adds (mcand & mbit) << SHIFT into acc_in,
// keeping bits below W only. Cells below SHIFT are plain wires.
module lowmul_row
  import lowmul_pkg::*;
#(
  parameter int W     = 32,
  parameter int SHIFT = 1
) (
  input  logic [W-1:0]       acc_in,
  input  logic [W-SHIFT-1:0] mcand,
  input  logic               mbit,
  output logic [W-1:0]       acc_out
);

  for (genvar k = 0; k < SHIFT; k++) begin : g_pass
    assign acc_out[k] = acc_in[k];
  end

  if (SHIFT == W-1) begin : g_last
    // single half-adder sum, its carry would leave the kept bits
    assign acc_out[W-1] = acc_in[W-1] ^ (mcand[0] & mbit);
  end else begin : g_body
    logic [W-2-SHIFT:0] cy;
    for (genvar k = SHIFT; k < W; k++) begin : g_bit
      logic pp;
      assign pp = mcand[k-SHIFT] & mbit;
      if (k == SHIFT) begin : g_half
        assign acc_out[k] = acc_in[k] ^ pp;
        assign cy[0]      = acc_in[k] & pp;
      end else if (k < W-1) begin : g_full
        assign acc_out[k]     = fa_sum(acc_in[k], pp, cy[k-SHIFT-1]);
        assign cy[k-SHIFT]    = fa_carry(acc_in[k], pp, cy[k-SHIFT-1]);
      end else begin : g_top
        // carry out of the top bit is dropped (R7)
        assign acc_out[k] = fa_sum(acc_in[k], pp, cy[k-SHIFT-1]);
      end
    end
  end

endmodule

// File: rtl/lowmul_core.sv
// Combinational array: row 0 is the bare partial product, rows 1..W-1 add.
module lowmul_core #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] p
);

  logic [W-1:0] acc [W];

  assign acc[0] = a & {W{b[0]}};

  for (genvar j = 1; j < W; j++) begin : g_row
    lowmul_row #(.W(W), .SHIFT(j)) u_row (
      .acc_in (acc[j-1]),
      .mcand  (a[W-j-1:0]),
      .mbit   (b[j]),
      .acc_out(acc[j])
    );
  end

  assign p = acc[W-1];

endmodule

// File: rtl/lowmul_array.sv
module lowmul_array #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] mul_a,
  input  logic [W-1:0] mul_b,
  output logic [W-1:0] prod
);

  logic [W-1:0] low_w;

  lowmul_core #(.W(W)) u_core (
    .a(mul_a),
    .b(mul_b),
    .p(low_w)
  );

  always_ff @(posedge clk) begin
    if (rst) prod <= '0;
    else     prod <= low_w;
  end

  // R1: output reads zero right after reset is released
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (prod == '0));

  // R2: registered result is the truncated product of last cycle's operands
  a_r2_low_product: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (prod == ($past(mul_a) * $past(mul_b))));

  // R4: a zero operand forces a zero result
  a_r4_zero_operand: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(mul_a) == '0 || $past(mul_b) == '0)) |-> (prod == '0));

  // R5: multiplier of one passes the multiplicand through
  a_r5_unit_multiplier: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mul_b) == W'(1)) |-> (prod == $past(mul_a)));

endmodule

// File: tb/tb_lowmul_array.sv
module tb_lowmul_array;

  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] mul_a = '0;
  logic [W-1:0] mul_b = '0;
  logic [W-1:0] prod;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // pending operand pair whose result is due at the next sample point
  bit           pend_v = 1'b0;
  logic [W-1:0] pend_a, pend_b;
  string        pend_tag;
  bit           pend_signed;

  always #2.5 clk = ~clk;

  lowmul_array #(.W(W)) dut (
    .clk  (clk),
    .rst  (rst),
    .mul_a(mul_a),
    .mul_b(mul_b),
    .prod (prod)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called at a negedge: checks the result of the previous pair, then drives a new one.
  task automatic step(input logic [W-1:0] a, input logic [W-1:0] b, input string tag, input bit sgn);
    logic [63:0]    ufull;
    longint         sfull;
    logic [63:0]    sbits;
    if (pend_v) begin
      ufull = {32'b0, pend_a} * {32'b0, pend_b};
      check({pend_tag, " unsigned"}, prod, ufull[W-1:0]);
      if (pend_signed) begin
        sfull = longint'($signed(pend_a)) * longint'($signed(pend_b));
        sbits = 64'(sfull);
        check("R3 signed", prod, sbits[W-1:0]);
      end
    end
    mul_a = a;
    mul_b = b;
    pend_a = a;
    pend_b = b;
    pend_tag = tag;
    pend_signed = sgn;
    pend_v = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    logic [W-1:0] vals [3];
    vals[0] = '0;
    vals[1] = 32'd1;
    vals[2] = '1;
    mul_a = 32'h1234_5678;
    mul_b = 32'h0000_0003;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 reset value", prod, '0);
    @(negedge clk);
    // R1: the first computed result only arrives after the first clock out of reset
    mul_a = 32'h0000_0002;
    mul_b = 32'h0000_0005;
    pend_a = mul_a; pend_b = mul_b; pend_tag = "R2 first"; pend_signed = 1'b0; pend_v = 1'b1;
    @(negedge clk);

    // R4, R5 and R3: all pairs from {0,1,-1}
    for (int i = 0; i < 3; i++)
      for (int j = 0; j < 3; j++)
        step(vals[i], vals[j], (i == 0 || j == 0) ? "R4 zero" : "R5 unit", 1'b1);

    // R8: 2^i * 1 and x * 2^j
    for (int i = 0; i < W; i++) step(W'(1) << i, W'(1), "R8 pow2 times one", 1'b0);
    for (int i = 0; i < W; i++) step(32'hA5C3_0F69, W'(1) << i, "R8 single multiplier bit", 1'b0);

    // R6: -1 * 2^i
    for (int i = 0; i < W; i++) step('1, W'(1) << i, "R6 minus one", 1'b1);

    // R7: (3<<i)*3, carries past the top bit dropped
    for (int i = 0; i < W; i++) step(W'(3) << i, W'(3), "R7 truncation", 1'b1);
    step('1, '1, "R7 all ones", 1'b1);
    step(32'h8000_0000, 32'h8000_0000, "R7 top bits", 1'b1);

    // R5 other order
    step(W'(1), 32'hDEAD_BEEF, "R5 unit multiplicand", 1'b0);

    // R2/R3 random pairs
    for (int n = 0; n < 2000; n++)
      step($urandom, $urandom, (n % 2 == 0) ? "R2 random" : "R3 random", n[0]);

    step('0, '0, "R4 flush", 1'b0);
    pend_v = 1'b0;
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule